// File: doc/BRIEF.md
# Double-Precision Compare Unit

This unit compares two IEEE-754 binary64 operands and returns a one-hot four-bit condition code. It also raises invalid-operation status pulses whenever NaN operands appear. Each operation picks one of two modes. In ordered mode, any NaN counts as an invalid compare. In unordered mode, quiet NaNs pass silently. An invalid-exception-enable input decides whether a signalling NaN in ordered mode also reports the invalid-compare condition.

To start an operation, the caller presents both operands, the mode bit and the enable bit with a one-cycle valid strobe. One clock later the unit returns a done pulse. With it come the condition code, a four-bit result-class field image and the two status pulses. The status of each operation starts from zero, so nothing carries over from an earlier compare. The less / greater / equal evaluation always runs, even when NaN operands are present. In that case the unordered code replaces its result.

Top module: `dcmp_unit`

## Requirements
- R1: After reset, out_done, out_cc, out_class, flag_snan_inv and flag_cmp_inv are all 0.
- R2: out_done is high in exactly the cycle after each cycle with in_valid high, and low in every other cycle.
- R3: For non-NaN operands, out_cc is 4'b1000 when A < B, 4'b0100 when A > B and 4'b0010 when they are equal. The ordering is sign-magnitude: negative values order by reversed magnitude, and ±infinity are the extremes.
- R4: +0 and -0 compare equal in every sign combination (out_cc = 4'b0010).
- R5: A NaN has exponent bits [62:52] all ones and fraction [51:0] nonzero. When either operand is a NaN, out_cc is exactly 4'b0001.
- R6: A signalling NaN is a NaN with bit 51 = 0. When either operand is a signalling NaN, flag_snan_inv pulses with done and out_cc = 4'b0001.
- R7: With a signalling NaN operand, flag_cmp_inv pulses only when ordered_mode = 1 and inv_trap_en = 0. It never pulses in unordered mode.
- R8: A quiet NaN is a NaN with bit 51 = 1. When quiet NaNs are present and no operand is a signalling NaN, flag_snan_inv stays 0. In that case flag_cmp_inv equals ordered_mode, whatever the value of inv_trap_en.
- R9: The two flags are high only in a done cycle. They reflect only the current operation: an earlier flagged compare leaves no flag set on a later clean one.
- R10: On each done, out_class is replaced by the new condition code and not merged with its old contents. Both out_class and out_cc hold until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Start strobe, one cycle per operation |
| opnd_a | input | 64 | First binary64 operand |
| opnd_b | input | 64 | Second binary64 operand |
| ordered_mode | input | 1 | 1 = ordered compare, 0 = unordered |
| inv_trap_en | input | 1 | Invalid-operation exception enable |
| out_done | output | 1 | Result valid pulse |
| out_cc | output | 4 | Condition code: 8 lt, 4 gt, 2 eq, 1 unordered |
| out_class | output | 4 | Result-class field image |
| flag_snan_inv | output | 1 | Signalling-NaN invalid pulse |
| flag_cmp_inv | output | 1 | Invalid-compare pulse |

## Verification
The hardest situation to reach is a signalling NaN in ordered mode, because there the invalid-compare pulse depends on the enable bit. A second hard case is a mixed pair in which one operand is a signalling NaN and the other is a quiet NaN. Here the signalling case must win even though quiet-NaN logic would raise the compare flag unconditionally. The stimulus crosses a table of special values (both zeros, both infinities, extreme finite and subnormal values, and signalling and quiet NaNs of both signs) against itself, in all four mode/enable settings. Random operand pairs with occasional forced NaN exponents run back to back, which also shows that flags from one compare do not carry into the next.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam logic [3:0] CC_LT = 4'b1000;
  localparam logic [3:0] CC_GT = 4'b0100;
  localparam logic [3:0] CC_EQ = 4'b0010;
  localparam logic [3:0] CC_UN = 4'b0001;

  typedef struct packed {
    logic nan;
    logic snan;
    logic qnan;
    logic zero;
  } opnd_class_t;
endpackage

// File: rtl/dcmp_classify.sv
module dcmp_classify
  import dcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] opnd,
  output opnd_class_t           cls
);
  localparam int W = 1 + EXP_W + FRAC_W;

  logic exp_all_ones;
  logic frac_nonzero;

  assign exp_all_ones = &opnd[W-2:FRAC_W];
  assign frac_nonzero = |opnd[FRAC_W-1:0];

  always_comb begin
    cls.nan  = exp_all_ones && frac_nonzero;
    cls.snan = cls.nan && !opnd[FRAC_W-1];
    cls.qnan = cls.nan && opnd[FRAC_W-1];
    cls.zero = ~|opnd[W-2:0];
  end
endmodule

// File: rtl/dcmp_order.sv
module dcmp_order #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] opnd_a,
  input  logic [EXP_W+FRAC_W:0] opnd_b,
  input  logic                  both_zero,
  output logic                  lt,
  output logic                  gt,
  output logic                  eq
);
  localparam int W = 1 + EXP_W + FRAC_W;

  // Map sign-magnitude to an unsigned key that orders monotonically.
  function automatic logic [W-1:0] order_key(input logic [W-1:0] v);
    if (v[W-1]) order_key = ~v;
    else        order_key = v ^ {1'b1, {(W-1){1'b0}}};
  endfunction

  logic [W-1:0] key_a;
  logic [W-1:0] key_b;

  assign key_a = order_key(opnd_a);
  assign key_b = order_key(opnd_b);

  always_comb begin
    eq = both_zero || (opnd_a == opnd_b);
    lt = !eq && (key_a < key_b);
    gt = !eq && !lt;
  end
endmodule

// File: rtl/dcmp_flags.sv
module dcmp_flags
  import dcmp_pkg::*;
(
  input  opnd_class_t cls_a,
  input  opnd_class_t cls_b,
  input  logic        ordered_mode,
  input  logic        inv_trap_en,
  input  logic        lt,
  input  logic        gt,
  output logic        snan_any,
  output logic        qnan_any,
  output logic [3:0]  cc_next,
  output logic        snan_inv_next,
  output logic        cmp_inv_next
);
  assign snan_any = cls_a.snan || cls_b.snan;
  assign qnan_any = cls_a.qnan || cls_b.qnan;

  always_comb begin
    snan_inv_next = 1'b0;
    cmp_inv_next  = 1'b0;
    if (snan_any) begin
      snan_inv_next = 1'b1;
      cmp_inv_next  = ordered_mode && !inv_trap_en;
    end else if (qnan_any) begin
      cmp_inv_next  = ordered_mode;
    end
  end

  always_comb begin
    if (snan_any || qnan_any) cc_next = CC_UN;
    else if (lt)              cc_next = CC_LT;
    else if (gt)              cc_next = CC_GT;
    else                      cc_next = CC_EQ;
  end
endmodule

// File: rtl/dcmp_unit.sv
module dcmp_unit
  import dcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [EXP_W+FRAC_W:0] opnd_a,
  input  logic [EXP_W+FRAC_W:0] opnd_b,
  input  logic                  ordered_mode,
  input  logic                  inv_trap_en,
  output logic                  out_done,
  output logic [3:0]            out_cc,
  output logic [3:0]            out_class,
  output logic                  flag_snan_inv,
  output logic                  flag_cmp_inv
);
  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][W-1:0] opnd_pair;
  opnd_class_t              cls [N_OPND];

  assign opnd_pair = {opnd_b, opnd_a};

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    dcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .opnd (opnd_pair[g]),
      .cls  (cls[g])
    );
  end

  logic lt_w, gt_w, eq_w;
  logic snan_any_w, qnan_any_w;
  logic [3:0] cc_next_w;
  logic snan_inv_w, cmp_inv_w;

  dcmp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .both_zero (cls[0].zero && cls[1].zero),
    .lt        (lt_w),
    .gt        (gt_w),
    .eq        (eq_w)
  );

  dcmp_flags u_flags (
    .cls_a         (cls[0]),
    .cls_b         (cls[1]),
    .ordered_mode  (ordered_mode),
    .inv_trap_en   (inv_trap_en),
    .lt            (lt_w),
    .gt            (gt_w),
    .snan_any      (snan_any_w),
    .qnan_any      (qnan_any_w),
    .cc_next       (cc_next_w),
    .snan_inv_next (snan_inv_w),
    .cmp_inv_next  (cmp_inv_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done      <= 1'b0;
      out_cc        <= '0;
      out_class     <= '0;
      flag_snan_inv <= 1'b0;
      flag_cmp_inv  <= 1'b0;
    end else begin
      out_done      <= in_valid;
      flag_snan_inv <= in_valid && snan_inv_w;
      flag_cmp_inv  <= in_valid && cmp_inv_w;
      if (in_valid) begin
        out_cc    <= cc_next_w;
        out_class <= cc_next_w;
      end
    end
  end

  // Assertions
  assert_done_follows_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  assert_done_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);
  assert_flags_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> (!flag_snan_inv && !flag_cmp_inv));
  assert_cc_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> ($countones(out_cc) == 1));
  assert_nan_unordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (snan_any_w || qnan_any_w)) |=> (out_cc == CC_UN));
  assert_snan_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && snan_any_w) |=> flag_snan_inv);
  assert_unord_no_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ordered_mode) |=> !flag_cmp_inv);
  assert_class_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_class == out_cc));
  assert_class_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_class));
endmodule

// File: tb/test_dcmp_unit.sv
module test_dcmp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic        ordered_mode = 1'b0;
  logic        inv_trap_en = 1'b0;
  logic        out_done;
  logic [3:0]  out_cc;
  logic [3:0]  out_class;
  logic        flag_snan_inv;
  logic        flag_cmp_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcmp_unit i_dcmp_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .ordered_mode(ordered_mode), .inv_trap_en(inv_trap_en),
    .out_done(out_done), .out_cc(out_cc), .out_class(out_class),
    .flag_snan_inv(flag_snan_inv), .flag_cmp_inv(flag_cmp_inv)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit mon_on = 0;

  typedef struct {
    logic [3:0] cc;
    logic       sn;
    logic       cm;
    string      tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction

  // Reference ordering written as sign and magnitude cases.
  function automatic logic [3:0] ref_cc(logic [63:0] a, logic [63:0] b);
    if (is_nan(a) || is_nan(b)) return 4'b0001;
    if (a[62:0] == 0 && b[62:0] == 0) return 4'b0010;
    if (a == b) return 4'b0010;
    if (a[63] != b[63]) return a[63] ? 4'b1000 : 4'b0100;
    if (!a[63]) return (a[62:0] < b[62:0]) ? 4'b1000 : 4'b0100;
    return (a[62:0] > b[62:0]) ? 4'b1000 : 4'b0100;
  endfunction

  function automatic string cc_tag(logic [63:0] a, logic [63:0] b);
    if (is_nan(a) || is_nan(b)) return "R5";
    if (a[62:0] == 0 && b[62:0] == 0) return "R4";
    return "R3";
  endfunction

  task automatic drive(logic [63:0] a, logic [63:0] b, logic ord, logic en);
    exp_t e;
    bit sa, sb_, qa, qb;
    @(negedge clk);
    opnd_a = a; opnd_b = b; ordered_mode = ord; inv_trap_en = en;
    in_valid = 1'b1;
    sa  = is_nan(a) && !a[51];
    sb_ = is_nan(b) && !b[51];
    qa  = is_nan(a) && a[51];
    qb  = is_nan(b) && b[51];
    e.cc  = ref_cc(a, b);
    e.tag = cc_tag(a, b);
    if (sa || sb_) begin
      e.sn = 1'b1; e.cm = ord && !en;
    end else if (qa || qb) begin
      e.sn = 1'b0; e.cm = ord;
    end else begin
      e.sn = 1'b0; e.cm = 1'b0;
    end
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every done pulse.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (out_done) begin
          if (sb.size() == 0) begin
            check("R2 done without request", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check({e.tag, " cc"}, out_cc, e.cc);
            check("R10 class field", out_class, e.cc);
            check("R6 snan flag", flag_snan_inv, e.sn);
            check("R7 R8 cmp flag", flag_cmp_inv, e.cm);
          end
        end else begin
          check("R9 flags idle", {flag_snan_inv, flag_cmp_inv}, 0);
        end
      end
    end
  end

  logic [63:0] specials [14];
  initial begin
    specials[0]  = 64'h0000_0000_0000_0000; // +0
    specials[1]  = 64'h8000_0000_0000_0000; // -0
    specials[2]  = 64'h3FF0_0000_0000_0000; // +1
    specials[3]  = 64'hBFF0_0000_0000_0000; // -1
    specials[4]  = 64'h7FF0_0000_0000_0000; // +inf
    specials[5]  = 64'hFFF0_0000_0000_0000; // -inf
    specials[6]  = 64'h7FEF_FFFF_FFFF_FFFF; // max finite
    specials[7]  = 64'h0000_0000_0000_0001; // min subnormal
    specials[8]  = 64'hC004_0000_0000_0000; // -2.5
    specials[9]  = 64'h7FF8_0000_0000_0000; // +qnan
    specials[10] = 64'hFFF8_0000_0000_0001; // -qnan
    specials[11] = 64'h7FF0_0000_0000_0001; // +snan
    specials[12] = 64'h7FF4_0000_0000_0000; // +snan
    specials[13] = 64'hFFF7_FFFF_FFFF_FFFF; // -snan
  end

  initial begin
    logic [63:0] lfsr;
    lfsr = 64'h1234_5678_9ABC_DEF1;
    repeat (3) @(negedge clk);
    check("R1 done reset", out_done, 0);
    check("R1 cc reset", out_cc, 0);
    check("R1 class reset", out_class, 0);
    check("R1 flags reset", {flag_snan_inv, flag_cmp_inv}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {out_done, flag_snan_inv, flag_cmp_inv}, 0);
    mon_on = 1'b1;

    // R2 single op then idle: done exactly one cycle.
    drive(specials[2], specials[3], 1'b0, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    check("R2 done pulse", out_done, 1);
    @(negedge clk);
    check("R2 done low", out_done, 0);
    check("R10 class holds", out_class, 4'b0100);

    // R9: flagged op followed directly by a clean op.
    drive(specials[11], specials[2], 1'b1, 1'b0);
    drive(specials[2], specials[2], 1'b1, 1'b0);
    idle(3);

    // Full cross of specials in all mode/enable settings (R3-R8).
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 14; i++) begin
        for (int j = 0; j < 14; j++) begin
          drive(specials[i], specials[j], m[0], m[1]);
        end
      end
      idle(2);
    end

    // Random pairs, some with forced NaN exponent.
    for (int k = 0; k < 600; k++) begin
      logic [63:0] a, b;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      a = lfsr;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
      b = (k % 5 == 0) ? a : lfsr;
      if (k % 7 == 3) a[62:52] = 11'h7FF;
      if (k % 11 == 5) b[62:52] = 11'h7FF;
      drive(a, b, lfsr[3], lfsr[9]);
      if (k % 9 == 0) idle(1);
    end
    idle(4);
    check("R2 all requests answered", sb.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired R2 actual=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule